// File: doc/BRIEF.md
# Memory-Card Slot Status Registers

This block is a small word-addressed register window on a platform control bus. It serves two fixed identification words and a status word for one memory-card slot. Two level signals come in from the slot: a write-protect level and a card-present pulse or level. One interrupt output goes to a secondary interrupt controller.

The write-protect status is a live view of its input, with no storage. The card-present status is a sticky flag. A high card-present input sets it, and it stays set after the input falls. While the flag is set, the interrupt output is high. Software clears the flag by writing the status word with the card-present data bit at one. The flash-programming word is a placeholder: it reads zero and ignores writes.

Reads are combinational. `rd_data` shows the addressed word in the same cycle that `rd_en` is high, and it is zero when `rd_en` is low. Writes take effect at the next rising clock edge.

Top module: `slot_status_regs`

## Requirements
- R1: A read of word index 0 returns the identification constant 0x41034003.
- R2: A read of word index 3 returns the decode constant 0x00000011.
- R3: A read of word index 1 returns zero. Writes of any data to word indices 0, 1 and 3, or to any undefined index, leave every readable word and `card_irq` unchanged.
- R4: Bit 0 of the status word (word index 2) equals `wp_level` in the same cycle as the read.
- R5: When `card_in` is high at a rising edge, bit 3 of the status word and `card_irq` are high after that edge. A later low `card_in` does not clear them.
- R6: A write to word index 2 with data bit 3 at one clears status bit 3 and `card_irq` at that edge, provided `card_in` is low. A write with data bit 3 at zero changes nothing, whatever the other data bits hold.
- R7: When `card_in` is high at the same edge as a clearing write, the set wins and status bit 3 stays at one.
- R8: Status bits 31..4, 2 and 1 read zero. Reset clears status bit 3 and `card_irq`. Word indices 4 and above read zero, and `rd_data` is zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe; selects the word shown on `rd_data` |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | ADDR_W (8) | Word index |
| wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, combinational |
| wp_level | input | 1 | Write-protect level from the slot |
| card_in | input | 1 | Card-inserted indication from the slot |
| card_irq | output | 1 | Interrupt request, high while the card flag is set |

## Verification
The assertions assume that `card_in` and `wp_level` are already synchronous to `clk`. They also assume that `addr`, `wdata`, `rd_en` and `wr_en` are stable around each rising edge. The bench meets these conditions by changing every input only on the falling edge. The read checks are sampled one nanosecond after that falling edge. The bench sweeps all 256 word indices for reads and writes. It also sweeps every single-bit write pattern into the status word, with the card flag both set and clear. It also drives `card_in` high during a clearing write, so the set/clear priority is tested at the edge where both occur.

// File: rtl/slot_regs_pkg.sv
package slot_regs_pkg;
  localparam int unsigned NUM_WORDS   = 4;
  localparam int unsigned WIDX_ID     = 0;
  localparam int unsigned WIDX_FLASH  = 1;
  localparam int unsigned WIDX_STATUS = 2;
  localparam int unsigned WIDX_DECODE = 3;
  localparam int unsigned BIT_WP      = 0;
  localparam int unsigned BIT_CARD    = 3;

  // next value of the sticky card flag: a set always beats a clear
  function automatic logic card_flag_next(input logic cur, input logic set_req,
                                          input logic clr_req);
    return set_req | (cur & ~clr_req);
  endfunction

  // the status write only clears when the card bit of the data is one
  function automatic logic card_clear_req(input logic wr, input logic hit_status,
                                          input logic data_card_bit);
    return wr & hit_status & data_card_bit;
  endfunction
endpackage

// File: rtl/slot_reg_decode.sv
module slot_reg_decode #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned N_WORDS = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_WORDS-1:0] hit
);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_hit
    assign hit[g] = (addr == ADDR_W'(g));
  end

  always_comb begin
    assert ($onehot0(hit)) else $error("AST_DECODE_ONEHOT"); // R8
  end
endmodule

// File: rtl/slot_sticky_flag.sv
module slot_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  import slot_regs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= card_flag_next(flag, set_req, clr_req);
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> flag) else $error("AST_FLAG_SET"); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag) else $error("AST_FLAG_STICKY"); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !flag) else $error("AST_FLAG_CLEAR"); // R6
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && set_req) |=> flag) else $error("AST_FLAG_SET_WINS"); // R7
endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wp_level,
  input  logic              card_in,
  output logic              card_irq
);
  import slot_regs_pkg::*;

  logic [NUM_WORDS-1:0] hit;
  logic                 card_clr;
  logic                 card_flag;
  logic [DATA_W-1:0]    status_word;
  logic [DATA_W-1:0]    wdata_unused;

  slot_reg_decode #(.ADDR_W(ADDR_W), .N_WORDS(NUM_WORDS)) u_decode (
    .addr (addr),
    .hit  (hit)
  );

  assign card_clr = card_clear_req(wr_en, hit[WIDX_STATUS], wdata[BIT_CARD]);

  slot_sticky_flag u_card_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (card_in),
    .clr_req (card_clr),
    .flag    (card_flag)
  );

  assign wdata_unused = wdata;
  assign card_irq     = card_flag;

  always_comb begin
    status_word           = '0;
    status_word[BIT_WP]   = wp_level;
    status_word[BIT_CARD] = card_flag;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (hit[WIDX_ID])     rd_data = ID_VALUE;
      if (hit[WIDX_STATUS]) rd_data = status_word;
      if (hit[WIDX_DECODE]) rd_data = DECODE_VALUE;
    end
  end

  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(WIDX_ID)) |-> rd_data == ID_VALUE)
    else $error("AST_ID_WORD"); // R1
  AST_DECODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(WIDX_DECODE)) |-> rd_data == DECODE_VALUE)
    else $error("AST_DECODE_WORD"); // R2
  AST_FLASH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(WIDX_FLASH)) |-> rd_data == '0)
    else $error("AST_FLASH_ZERO"); // R3
  AST_OTHER_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != ADDR_W'(WIDX_STATUS) && !card_in) |=> $stable(card_irq))
    else $error("AST_OTHER_WRITE_NO_EFFECT"); // R3
  AST_WP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(WIDX_STATUS)) |-> rd_data[BIT_WP] == wp_level)
    else $error("AST_WP_LIVE"); // R4
  AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(WIDX_STATUS)) |-> rd_data[BIT_CARD] == card_irq)
    else $error("AST_IRQ_MATCHES_STATUS"); // R5
  AST_IRQ_AFTER_CARD: assert property (@(posedge clk) disable iff (!rst_n)
    card_in |=> card_irq) else $error("AST_IRQ_AFTER_CARD"); // R5
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(WIDX_STATUS) && wdata[BIT_CARD] && !card_in) |=> !card_irq)
    else $error("AST_CLEAR_DROPS_IRQ"); // R6
  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(WIDX_STATUS)) |-> (rd_data & ~DATA_W'(9)) == '0)
    else $error("AST_STATUS_SPARE_ZERO"); // R8
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || addr >= ADDR_W'(NUM_WORDS)) |-> rd_data == '0)
    else $error("AST_UNDEF_ZERO"); // R8
endmodule

// File: tb/test_slot_status_regs.sv
`timescale 1ns/1ps
module test_slot_status_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        wp_level = 1'b0;
  logic        card_in = 1'b0;
  logic        card_irq;

  int n_checks = 0;
  int n_fails  = 0;
  logic exp_card = 1'b0;

  always #2 clk = ~clk;

  slot_status_regs i_slot_status_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .wp_level(wp_level),
    .card_in(card_in), .card_irq(card_irq)
  );

  function automatic logic [31:0] expect_word(input int idx, input logic wp,
                                              input logic card);
    case (idx)
      0: return 32'h4103_4003;
      2: return (32'(card) << 3) + 32'(wp);
      3: return 32'h11;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int idx);
    case (idx)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      3: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic read_check(input int idx, input string req);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = 8'(idx);
    #1;
    check(req, rd_data, expect_word(idx, wp_level, exp_card));
    check(req, 32'(card_irq), 32'(exp_card));
  endtask

  task automatic write_word(input int idx, input logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b0;
    wr_en = 1'b1;
    addr  = 8'(idx);
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx == 2 && d[3] && !card_in) exp_card = 1'b0;
    if (card_in) exp_card = 1'b1;
  endtask

  task automatic card_pulse();
    @(negedge clk);
    card_in = 1'b1;
    @(negedge clk);
    card_in = 1'b0;
    exp_card = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    // reset state, with card_in high during reset (R8)
    card_in = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b1; addr = 8'd2; #1;
    check("R8 reset status", rd_data, 32'h0);
    check("R8 reset irq", 32'(card_irq), 32'h0);
    card_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R8: exhaustive read sweep, both write-protect levels
    for (int wp = 0; wp < 2; wp++) begin
      wp_level = wp[0];
      for (int a = 0; a < 256; a++) read_check(a, req_of(a));
    end

    // R8: no read strobe gives zero on every index
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      rd_en = 1'b0; addr = 8'(a); #1;
      check("R8 idle read", rd_data, 32'h0);
    end

    // R5: set by card_in, held after the input falls
    card_pulse();
    for (int k = 0; k < 4; k++) read_check(2, "R5 sticky");
    // R4 while card flag set
    wp_level = 1'b1; read_check(2, "R4 live with card");
    wp_level = 1'b0; read_check(2, "R4 live with card");

    // R3: writes of all ones to every index but the status word
    for (int a = 0; a < 256; a++) begin
      if (a != 2) begin
        write_word(a, 32'hFFFF_FFFF);
        @(negedge clk); rd_en = 1'b1; addr = 8'd2; #1;
        check("R3 other write", rd_data, expect_word(2, wp_level, 1'b1));
      end
    end
    for (int a = 0; a < 4; a++) read_check(a, "R3 words intact");

    // R6: single-bit write patterns into the status word, flag set and clear
    for (int st = 0; st < 2; st++) begin
      for (int b = 0; b < 32; b++) begin
        if (st == 1) card_pulse();
        write_word(2, 32'h1 << b);
        read_check(2, "R6 bit pattern");
        if (st == 1 && b == 3) check("R6 cleared", 32'(card_irq), 32'h0);
      end
    end
    card_pulse();
    write_word(2, 32'hFFFF_FFF7);
    read_check(2, "R6 bit3 zero keeps");
    write_word(2, 32'h8);
    read_check(2, "R6 clear");

    // R7: set wins over a clearing write in the same cycle
    card_pulse();
    @(negedge clk);
    card_in = 1'b1; wr_en = 1'b1; addr = 8'd2; wdata = 32'h8; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; card_in = 1'b0; exp_card = 1'b1;
    read_check(2, "R7 set wins");
    check("R7 irq held", 32'(card_irq), 32'h1);
    // R7: from a clear flag too
    write_word(2, 32'h8);
    @(negedge clk);
    card_in = 1'b1; wr_en = 1'b1; addr = 8'd2; wdata = 32'h8;
    @(negedge clk);
    wr_en = 1'b0; card_in = 1'b0; exp_card = 1'b1;
    read_check(2, "R7 set wins from clear");

    // R8: reset mid-run clears the flag
    @(negedge clk); rst_n = 1'b0; exp_card = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_check(2, "R8 reset clears");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule